// File: doc/BRIEF.md
# Sprite Table Copy Engine

This block copies a fixed run of 160 bytes from a 256-byte-aligned source page into sprite attribute memory, which starts at address 0xFE00. Software writes one byte, the source page number, to a configuration register. That write arms a one-step start delay. After the delay the engine walks through the page. Each transfer step writes the byte it fetched on the previous step and issues the read for the next byte. Reading the configuration register returns the page number that was last written.

The engine advances only on clock cycles where `step_en` is high, so a machine-cycle enable pulse paces it. It drives a synchronous memory port. A read issued in one cycle returns its data on `rd_data` in the following cycle. A write is presented as address plus data while `wr_en` is high. While a copy runs, `busy` tells surrounding logic to keep the processor away from the destination memory. Arbitration, the memories themselves and processor stalling are handled elsewhere.

The copy is pipelined through a one-byte holding register. A transfer therefore issues 161 reads. The first of these is a priming read with no write beside it, and the last read fetches a byte that is never stored. `busy` is high for exactly the 160 steps that perform writes.

Top module: `sat_dma`

## Requirements
- R1: After synchronous reset, `busy` is 0, `cfg_rdata` is 0, and neither `rd_en` nor `wr_en` is asserted, even with `step_en` high.
- R2: A `cfg_wr` stores `cfg_wdata`. From the next cycle, `cfg_rdata` returns that byte.
- R3: After a configuration write, the first step issues no read and no write. The second step issues only a read, of address {page, 0x00}. `busy` rises after that second step.
- R4: `busy` is high for exactly 160 steps per uninterrupted transfer and is low again afterwards.
- R5: An uninterrupted transfer makes exactly 160 writes, at ascending addresses 0xFE00 to 0xFE9F. The write to 0xFE00+i carries the byte read from {page, i}. This holds whether steps come back to back or spaced apart.
- R6: An uninterrupted transfer makes exactly 161 reads, at {page, 0x00} through {page, 0xA0} in order. Every read uses the current contents of the page register as its high byte.
- R7: In a cycle with `step_en` low, no read or write is issued, and the transfer position and `busy` hold.
- R8: A configuration write during a transfer re-arms the start delay. The next step still finishes one write of the old sequence, and its read already uses the new page at the following offset. The copy then restarts from offset 0 with the new page, with a priming read and 160 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Transfer step enable, one step per high cycle |
| cfg_wr | input | 1 | Page register write strobe |
| cfg_wdata | input | 8 | Source page number to write |
| cfg_rdata | output | 8 | Page register readback |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| wr_en | output | 1 | Sprite memory write request |
| wr_addr | output | 16 | Sprite memory write address |
| wr_data | output | 8 | Sprite memory write data |
| busy | output | 1 | Copy in progress, destination memory is reserved |

## Verification
Readback of the page is due one cycle after `cfg_wr`. `rd_en`, `wr_en` and their addresses respond within the same cycle as the `step_en` pulse that causes them. `busy` follows one cycle after the step that changes the position. The byte a write carries is the one returned one cycle after the read of the previous step, so the bench memory registers its output by one cycle. Inputs change just after the rising edge and every output is sampled at the falling edge of the step cycle. A scoreboard queues the expected reads and writes for each transfer and pops one entry per observed request, so both order and count are checked whatever the spacing between steps.

// File: rtl/sat_dma_pkg.sv
package sat_dma_pkg;

    localparam int unsigned DEF_ADDR_W      = 16;
    localparam int unsigned DEF_DATA_W      = 8;
    localparam int unsigned DEF_XFER_LEN    = 160;
    localparam int unsigned DEF_START_DELAY = 1;
    localparam logic [15:0] DEF_DEST_BASE   = 16'hFE00;

    // Where the transfer position counter stands.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // nothing to do
        PH_PRIME = 2'd1,   // first read only, no write yet
        PH_COPY  = 2'd2    // write held byte, read next byte
    } phase_e;

    // Memory actions taken on one step.
    typedef struct packed {
        logic rd;
        logic wr;
    } step_act_t;

    function automatic phase_e classify(input int unsigned pos, input int unsigned len);
        if (pos == 0)  return PH_IDLE;
        if (pos > len) return PH_PRIME;
        return PH_COPY;
    endfunction

    function automatic step_act_t actions(input phase_e ph, input logic step);
        step_act_t a;
        a.rd = step && (ph != PH_IDLE);
        a.wr = step && (ph == PH_COPY);
        return a;
    endfunction

endpackage

// File: rtl/sat_dma_seq.sv
module sat_dma_seq
    import sat_dma_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned XFER_LEN    = DEF_XFER_LEN,
    parameter int unsigned START_DELAY = DEF_START_DELAY,
    parameter int unsigned CNT_W       = $clog2(XFER_LEN + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] page,
    output logic [CNT_W-1:0]  pos
);
    localparam int unsigned DLY_W = (START_DELAY < 2) ? 1 : $clog2(START_DELAY + 1);
    localparam logic [CNT_W-1:0] POS_RELOAD = CNT_W'(XFER_LEN + 1);
    localparam logic [DLY_W-1:0] DLY_LOAD   = DLY_W'(START_DELAY);

    logic [DATA_W-1:0] page_q;
    logic [CNT_W-1:0]  pos_q, pos_d;
    logic [DLY_W-1:0]  dly_q, dly_d;

    // Position handling comes first, then the start delay, which may
    // override it with a fresh reload; a register write re-arms the delay.
    always_comb begin
        pos_d = pos_q;
        dly_d = dly_q;
        if (step_en) begin
            if (pos_q != '0) pos_d = pos_q - CNT_W'(1);
            if (dly_q != '0) begin
                dly_d = dly_q - DLY_W'(1);
                if (dly_q == DLY_W'(1)) pos_d = POS_RELOAD;
            end
        end
        if (cfg_wr) dly_d = DLY_LOAD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            pos_q  <= '0;
            dly_q  <= '0;
        end else begin
            pos_q <= pos_d;
            dly_q <= dly_d;
            if (cfg_wr) page_q <= cfg_wdata;
        end
    end

    assign page = page_q;
    assign pos  = pos_q;

    AST_CFG_STORES: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (page_q == $past(cfg_wdata)) && (dly_q == DLY_LOAD)); // R2

    AST_DELAY_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (step_en && dly_q == DLY_W'(1)) |=> (pos_q == POS_RELOAD)); // R8

    AST_POS_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step_en && dly_q != DLY_W'(1) && pos_q != '0) |=> (pos_q == $past(pos_q) - CNT_W'(1))); // R4

    AST_POS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(pos_q)); // R7

endmodule

// File: rtl/sat_dma_buf.sv
module sat_dma_buf
    import sat_dma_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] held
);
    logic              fill_q;
    logic [DATA_W-1:0] hold_q;

    // The memory answers one cycle after a read; the answer is captured
    // then, and bypassed straight through if a step lands in that cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= 1'b0;
            hold_q <= '0;
        end else begin
            fill_q <= rd_issue;
            if (fill_q) hold_q <= rd_data;
        end
    end

    assign held = fill_q ? rd_data : hold_q;

    AST_FILL_CAPTURES: assert property (@(posedge clk) disable iff (rst)
        fill_q |=> (hold_q == $past(rd_data))); // R5

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!fill_q && !rd_issue) |=> $stable(hold_q)); // R7

endmodule

// File: rtl/sat_dma_addr.sv
module sat_dma_addr
    import sat_dma_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned XFER_LEN = DEF_XFER_LEN,
    parameter int unsigned CNT_W    = $clog2(XFER_LEN + 2),
    parameter logic [ADDR_W-1:0] DEST_BASE = ADDR_W'(DEF_DEST_BASE)
) (
    input  logic              step_en,
    input  logic [CNT_W-1:0]  pos,
    input  logic [DATA_W-1:0] page,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              busy
);
    localparam int unsigned OFF_W = ADDR_W - DATA_W;

    phase_e      ph;
    step_act_t   act;
    logic [CNT_W:0] rd_off, wr_off;

    assign ph  = classify(int'(pos), XFER_LEN);
    assign act = actions(ph, step_en);

    // Offsets count up as the position counts down; the read runs one
    // byte ahead of the write.
    assign rd_off = (CNT_W+1)'(XFER_LEN + 1) - {1'b0, pos};
    assign wr_off = (CNT_W+1)'(XFER_LEN)     - {1'b0, pos};

    assign rd_en   = act.rd;
    assign wr_en   = act.wr;
    assign rd_addr = {page, OFF_W'(rd_off)};
    assign wr_addr = DEST_BASE + ADDR_W'(wr_off);
    assign busy    = (ph == PH_COPY);

endmodule

// File: rtl/sat_dma.sv
module sat_dma
    import sat_dma_pkg::*;
#(
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned XFER_LEN    = DEF_XFER_LEN,
    parameter int unsigned START_DELAY = DEF_START_DELAY,
    parameter logic [ADDR_W-1:0] DEST_BASE = ADDR_W'(DEF_DEST_BASE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy
);
    localparam int unsigned CNT_W = $clog2(XFER_LEN + 2);
    localparam int unsigned OFF_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] page;
    logic [CNT_W-1:0]  pos;

    sat_dma_seq #(
        .DATA_W(DATA_W), .XFER_LEN(XFER_LEN),
        .START_DELAY(START_DELAY), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst(rst), .step_en(step_en),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .page(page), .pos(pos)
    );

    sat_dma_addr #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_LEN(XFER_LEN),
        .CNT_W(CNT_W), .DEST_BASE(DEST_BASE)
    ) u_addr (
        .step_en(step_en), .pos(pos), .page(page),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy)
    );

    sat_dma_buf #(
        .DATA_W(DATA_W)
    ) u_buf (
        .clk(clk), .rst(rst), .rd_issue(rd_en),
        .rd_data(rd_data), .held(wr_data)
    );

    assign cfg_rdata = page;

    AST_WR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy); // R4

    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr >= DEST_BASE) && (wr_addr < DEST_BASE + ADDR_W'(XFER_LEN))); // R5

    AST_RD_FROM_PAGE: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr[ADDR_W-1:OFF_W] == cfg_rdata)); // R6

    AST_QUIET_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !step_en |-> (!rd_en && !wr_en)); // R7

    AST_BUSY_AFTER_PRIME: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(rd_en) && !$past(wr_en))); // R3

endmodule

// File: tb/tb_sat_dma.sv
`timescale 1ns/1ps
module tb_sat_dma;

    logic        clk = 1'b0;
    logic        rst;
    logic        step_en;
    logic        cfg_wr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        busy;

    always #10 clk = ~clk;   // 50 MHz

    sat_dma dut (
        .clk(clk), .rst(rst), .step_en(step_en),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy)
    );

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h5A;
    endfunction

    // Source memory: data returns the cycle after the request.
    always @(posedge clk) if (rd_en) rd_data <= src_byte(rd_addr);

    int n_chk = 0;
    int n_bad = 0;
    int rd_seen, wr_seen, busy_steps;
    bit done = 1'b0;
    logic [15:0] exp_rd_q[$];
    logic [23:0] exp_wr_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Monitor: pops the scoreboard as requests appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (step_en && busy) busy_steps++;
            if (!step_en) chk(!rd_en && !wr_en, "R7 request without step", {rd_en, wr_en}, 0);
            if (rd_en) begin
                rd_seen++;
                if (exp_rd_q.size() == 0) chk(1'b0, "R6 unexpected read", rd_addr, 0);
                else begin
                    logic [15:0] e;
                    e = exp_rd_q.pop_front();
                    chk(rd_addr == e, "R6 read address", rd_addr, e);
                end
            end
            if (wr_en) begin
                wr_seen++;
                if (exp_wr_q.size() == 0) chk(1'b0, "R5 unexpected write", {wr_addr, wr_data}, 0);
                else begin
                    logic [23:0] e;
                    e = exp_wr_q.pop_front();
                    chk({wr_addr, wr_data} == e, "R5 write address/data", {wr_addr, wr_data}, e);
                end
            end
        end
    end

    task automatic clear_counts();
        rd_seen = 0; wr_seen = 0; busy_steps = 0;
    endtask

    task automatic push_full(input logic [7:0] pg);
        for (int i = 0; i <= 160; i++) exp_rd_q.push_back({pg, 8'(i)});
        for (int i = 0; i < 160; i++)
            exp_wr_q.push_back({16'hFE00 + 16'(i), src_byte({pg, 8'(i)})});
    endtask

    task automatic steps(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step_en = 1'b1;
            @(posedge clk); #1;
            step_en = 1'b0;
            repeat (gap) begin @(posedge clk); #1; end
        end
    endtask

    task automatic run_transfer(input logic [7:0] pg, input int gap);
        clear_counts();
        push_full(pg);
        cfg_wr = 1'b1; cfg_wdata = pg;
        @(posedge clk); #1;
        cfg_wr = 1'b0; step_en = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == pg, "R2 readback", cfg_rdata, pg);
        chk(!rd_en && !wr_en && !busy, "R3 delay step quiet", {rd_en, wr_en, busy}, 0);
        @(posedge clk); #1;
        @(negedge clk);
        chk(rd_en && !wr_en && !busy && rd_addr == {pg, 8'h00}, "R3 priming read",
            {rd_en, wr_en, busy, rd_addr}, {3'b100, pg, 8'h00});
        @(posedge clk); #1;
        step_en = 1'b0;
        @(negedge clk);
        chk(busy, "R3 busy after priming", busy, 1);
        @(posedge clk); #1;
        steps(170, gap);
        @(negedge clk);
        chk(wr_seen == 160, "R5 write count", wr_seen, 160);
        chk(rd_seen == 161, "R6 read count", rd_seen, 161);
        chk(busy_steps == 160, "R4 busy steps", busy_steps, 160);
        chk(!busy, "R4 busy cleared", busy, 0);
        chk(exp_wr_q.size() == 0 && exp_rd_q.size() == 0, "R5 scoreboard drained",
            exp_wr_q.size() + exp_rd_q.size(), 0);
        @(posedge clk); #1;
    endtask

    task automatic run_restart(input logic [7:0] pa, input logic [7:0] pb);
        clear_counts();
        for (int i = 0; i <= 40; i++) exp_rd_q.push_back({pa, 8'(i)});
        for (int i = 0; i < 40; i++)
            exp_wr_q.push_back({16'hFE00 + 16'(i), src_byte({pa, 8'(i)})});
        cfg_wr = 1'b1; cfg_wdata = pa;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        steps(42, 0);
        @(negedge clk);
        chk(wr_seen == 40 && rd_seen == 41, "R8 progress before rewrite", {wr_seen[15:0], rd_seen[15:0]}, {16'd40, 16'd41});
        chk(busy, "R8 busy mid transfer", busy, 1);
        @(posedge clk); #1;
        clear_counts();
        exp_rd_q.push_back({pb, 8'd41});
        exp_wr_q.push_back({16'hFE00 + 16'd40, src_byte({pa, 8'd40})});
        push_full(pb);
        cfg_wr = 1'b1; cfg_wdata = pb;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        @(negedge clk);
        chk(cfg_rdata == pb, "R8 new page readback", cfg_rdata, pb);
        @(posedge clk); #1;
        steps(170, 0);
        @(negedge clk);
        chk(wr_seen == 161, "R8 writes after rewrite", wr_seen, 161);
        chk(rd_seen == 162, "R8 reads after rewrite", rd_seen, 162);
        chk(busy_steps == 161, "R8 busy steps after rewrite", busy_steps, 161);
        chk(exp_wr_q.size() == 0 && exp_rd_q.size() == 0, "R8 scoreboard drained",
            exp_wr_q.size() + exp_rd_q.size(), 0);
        @(posedge clk); #1;
    endtask

    initial begin
        rst = 1'b1; step_en = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0;
        clear_counts();
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk(!rd_en && !wr_en, "R1 no requests in reset", {rd_en, wr_en}, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !rd_en && !wr_en, "R1 idle after reset", {busy, rd_en, wr_en}, 0);
        chk(cfg_rdata == 8'h00, "R1 page cleared", cfg_rdata, 0);
        @(posedge clk); #1;
        step_en = 1'b0;

        run_transfer(8'h3C, 0);

        begin
            logic [7:0] keep;
            keep = cfg_rdata;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                chk(!busy && cfg_rdata == keep, "R7 idle hold", {busy, cfg_rdata}, {1'b0, keep});
                @(posedge clk); #1;
            end
        end

        run_transfer(8'hFF, 2);
        run_restart(8'h12, 8'h81);

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            report();
            $finish;
        end
    end

endmodule